// File: doc/BRIEF.md
# Real-Time Clock Status and Alarm Interrupt Register

This block holds the read-only status byte of a real-time clock subsystem. The byte carries three flags. The first warns that an ADC result update is coming soon. The second mirrors a low-battery comparator. The third latches a time-equals-alarm event. The block also drives an active-high interrupt line from the alarm flag, gated by an enable bit.

The block keeps its own ADC update schedule. It counts timebase ticks and issues one update strobe every `PERIOD_TICKS` ticks. The pending flag is raised exactly `LEAD_TICKS` ticks before each strobe. A reader that sees the flag at 0 therefore knows a quiet window lies ahead, and a reader that sees it at 1 knows the update is close. With a 32.768 kHz tick and a lead of 8 ticks, the quiet window is about 244 µs.

Software clears the alarm flag as a side effect. Any read or write that lands in the alarm register address range clears it, and no explicit acknowledge is needed.

Top module: `rtc_status_reg`

## Requirements
- R1: A read of the status address (default 0xD) returns, on `rd_data_o` in the cycle after the access, the byte with bit 7 = update pending, bit 6 = low battery, bit 0 = alarm flag and bits 5..1 = 0. In every other cycle `rd_data_o` is 0x00.
- R2: `adc_upd_o` pulses for one cycle after every `PERIOD_TICKS`-th tick. The pending flag rises after the tick that lies exactly `LEAD_TICKS` ticks before that update tick.
- R3: The pending flag falls at the same clock edge that raises `adc_upd_o`. It stays 0 until the next lead point.
- R4: The low-battery bit is the comparator input registered every cycle, including during reset.
- R5: A match pulse sets the alarm flag at the next clock edge.
- R6: `irq_o` is 1 in the cycle after a cycle in which both the alarm flag and `alarm_ie_i` are 1, and 0 otherwise.
- R7: Any read or write to the alarm addresses (default 0x8, 0x9, 0xA) clears the alarm flag.
- R8: When a match pulse and an alarm-address access fall in the same cycle, the flag ends up set.
- R9: Writes to the status address change nothing. Reads of the status address do not clear the alarm flag.
- R10: A synchronous reset clears the pending flag, the alarm flag, `irq_o`, `adc_upd_o` and `rd_data_o`, and restarts the tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase tick |
| lowbat_i | input | 1 | Low-battery comparator output, 1 = low |
| alarm_match_i | input | 1 | One-cycle time-equals-alarm pulse |
| alarm_ie_i | input | 1 | Alarm interrupt enable |
| acc_en_i | input | 1 | Register access strobe |
| acc_wr_i | input | 1 | Access is a write when 1 |
| acc_addr_i | input | ADDR_W | Register address |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Active-high alarm interrupt |
| adc_upd_o | output | 1 | One-cycle ADC update strobe |

## Verification
Every output is a single register, so `rd_data_o`, `irq_o` and `adc_upd_o` respond one clock after the edge that samples their cause. A match pulse is therefore visible in a status read issued one cycle later, and in `irq_o` two cycles after the pulse. The bench keeps a cycle model that advances at each rising edge from the inputs driven at the preceding falling edge. It compares all three outputs at the following falling edge, so every comparison falls exactly one register stage after its stimulus.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  localparam int BIT_PEND = 7;
  localparam int BIT_LOWB = 6;
  localparam int BIT_ALRM = 0;

  typedef struct packed {
    logic pend;
    logic lowb;
    logic alrm;
  } stat_flags_t;

  function automatic logic [7:0] pack_status(input stat_flags_t f);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_PEND] = f.pend;
    b[BIT_LOWB] = f.lowb;
    b[BIT_ALRM] = f.alrm;
    return b;
  endfunction
endpackage

// File: rtl/stat_upd_sched.sv
module stat_upd_sched #(
  parameter int PERIOD_TICKS = 32,
  parameter int LEAD_TICKS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic pend_o,
  output logic upd_o
);
  localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);
  localparam logic [CNT_W-1:0] RISE = CNT_W'(PERIOD_TICKS - 1 - LEAD_TICKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      pend_o <= 1'b0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (tick_i) begin
        if (cnt == LAST) begin
          cnt    <= '0;
          upd_o  <= 1'b1;
          pend_o <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == RISE) pend_o <= 1'b1;
        end
      end
    end
  end

  AST_UPD_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> !pend_o); // R3
  AST_UPD_AFTER_LEAD: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt == LAST) |-> pend_o); // R2
endmodule

// File: rtl/stat_alarm_flag.sv
module stat_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic match_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (match_i)    flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      irq_o <= flag_o & ie_i;
    end
  end

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
    match_i |=> flag_o); // R5
  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !match_i) |=> !flag_o); // R7
  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !flag_o |=> !irq_o); // R6
endmodule

// File: rtl/stat_bus_if.sv
module stat_bus_if
  import rtc_stat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 13,
  parameter int ALM_BASE  = 8,
  parameter int ALM_NUM   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  stat_flags_t       flags_i,
  output logic              alm_acc_o,
  output logic [7:0]        rd_data_o
);
  logic [ALM_NUM-1:0] alm_hit;

  for (genvar g = 0; g < ALM_NUM; g++) begin : g_alm_dec
    assign alm_hit[g] = (addr_i == ADDR_W'(ALM_BASE + g));
  end

  assign alm_acc_o = en_i & (|alm_hit);

  logic rd_stat;
  assign rd_stat = en_i & ~wr_i & (addr_i == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= 8'h00;
    else     rd_data_o <= rd_stat ? pack_status(flags_i) : 8'h00;
  end

  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (rd_data_o == 8'h00)); // R1
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_stat_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int STAT_ADDR    = 13,
  parameter int ALM_BASE     = 8,
  parameter int ALM_NUM      = 3,
  parameter int PERIOD_TICKS = 32,
  parameter int LEAD_TICKS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              lowbat_i,
  input  logic              alarm_match_i,
  input  logic              alarm_ie_i,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_o,
  output logic              adc_upd_o
);
  logic        pend, alm_flag, alm_acc, lowb_q;
  stat_flags_t flags;

  always_ff @(posedge clk) lowb_q <= lowbat_i;

  stat_upd_sched #(.PERIOD_TICKS(PERIOD_TICKS), .LEAD_TICKS(LEAD_TICKS)) i_sched (
    .clk(clk), .rst(rst), .tick_i(tick_i), .pend_o(pend), .upd_o(adc_upd_o));

  stat_alarm_flag i_alarm (
    .clk(clk), .rst(rst), .match_i(alarm_match_i), .clr_i(alm_acc),
    .ie_i(alarm_ie_i), .flag_o(alm_flag), .irq_o(irq_o));

  assign flags = '{pend: pend, lowb: lowb_q, alrm: alm_flag};

  stat_bus_if #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ALM_BASE(ALM_BASE),
                .ALM_NUM(ALM_NUM)) i_bus (
    .clk(clk), .rst(rst), .en_i(acc_en_i), .wr_i(acc_wr_i), .addr_i(acc_addr_i),
    .flags_i(flags), .alm_acc_o(alm_acc), .rd_data_o(rd_data_o));

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && !adc_upd_o && rd_data_o == 8'h00)); // R10
endmodule

// File: tb/test_rtc_status_reg.sv
module test_rtc_status_reg;
  localparam int P = 32;
  localparam int L = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 0, lowbat = 0, match = 0, ie = 0, en = 0, wr = 0;
  logic [3:0] addr = 4'h0;
  logic [7:0] rd_data;
  logic irq, upd;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_status_reg i_rtc_status_reg (
    .clk(clk), .rst(rst), .tick_i(tick), .lowbat_i(lowbat), .alarm_match_i(match),
    .alarm_ie_i(ie), .acc_en_i(en), .acc_wr_i(wr), .acc_addr_i(addr),
    .rd_data_o(rd_data), .irq_o(irq), .adc_upd_o(upd));

  // reference model, advanced at each rising edge
  int   m_tc = 0;
  logic m_pend = 0, m_upd = 0, m_alm = 0, m_irq = 0, m_lb = 0;
  logic [7:0] m_rd = 0;

  function automatic bit is_alarm_addr(input logic [3:0] a);
    return (a >= 4'h8) && (a <= 4'hA);
  endfunction

  function automatic logic [7:0] status_byte(input logic p, input logic b, input logic a);
    return {p, b, 5'b00000, a};
  endfunction

  always @(posedge clk) begin
    logic n_pend, n_upd, n_alm, n_irq;
    logic [7:0] n_rd;
    int n_tc;
    cyc++;
    if (rst) begin
      n_tc = 0; n_pend = 0; n_upd = 0; n_alm = 0; n_irq = 0; n_rd = 0;
    end else begin
      n_tc = m_tc; n_pend = m_pend; n_upd = 0;
      if (tick) begin
        if (m_tc == P - 1) begin n_tc = 0; n_upd = 1; n_pend = 0; end
        else begin
          n_tc = m_tc + 1;
          if (n_tc == P - L) n_pend = 1;
        end
      end
      n_alm = match ? 1'b1 : ((en && is_alarm_addr(addr)) ? 1'b0 : m_alm);
      n_irq = m_alm & ie;
      n_rd  = (en && !wr && addr == 4'hD) ? status_byte(m_pend, m_lb, m_alm) : 8'h00;
    end
    m_lb = lowbat;
    m_tc = n_tc; m_pend = n_pend; m_upd = n_upd; m_alm = n_alm; m_irq = n_irq; m_rd = n_rd;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1", {2'b00, rd_data[5:1], 1'b0}, 8'h00);
    chk("R3", {7'd0, rd_data[7]}, {7'd0, m_rd[7]});
    chk("R4", {7'd0, rd_data[6]}, {7'd0, m_rd[6]});
    chk("R7", {7'd0, rd_data[0]}, {7'd0, m_rd[0]});
    chk("R6", {7'd0, irq}, {7'd0, m_irq});
    chk("R2", {7'd0, upd}, {7'd0, m_upd});
  endtask

  task automatic step(input logic t, input logic m, input logic e, input logic w,
                      input logic [3:0] a);
    tick = t; match = m; en = e; wr = w; addr = a;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd1673));
    @(negedge clk);
    lowbat = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", rd_data, 8'h00);
    chk("R10", {6'd0, irq, upd}, 8'h00);
    rst = 0;
    // R4 low battery followed through reset: first read shows bit 6
    step(0, 0, 1, 0, 4'hD);
    step(0, 0, 0, 0, 4'h0);
    chk("R4", rd_data, 8'h00);
    step(0, 0, 1, 0, 4'hD);
    chk("R4", rd_data, 8'h40);
    // R5/R6 match then read
    ie = 1;
    step(0, 1, 0, 0, 4'h0);
    step(0, 0, 1, 0, 4'hD);
    chk("R5", rd_data, 8'h41);
    step(0, 0, 0, 0, 4'h0);
    chk("R6", {7'd0, irq}, 8'h01);
    // R9 write to status ignored, read does not clear
    step(0, 0, 1, 1, 4'hD);
    chk("R9", rd_data, 8'h00);
    step(0, 0, 1, 0, 4'hD);
    chk("R9", rd_data, 8'h41);
    // R8 match and alarm access together
    step(0, 1, 1, 1, 4'h9);
    step(0, 0, 1, 0, 4'hD);
    chk("R8", rd_data, 8'h41);
    // R7 clear by write to last alarm address
    step(0, 0, 1, 1, 4'hA);
    step(0, 0, 1, 0, 4'hD);
    chk("R7", rd_data, 8'h40);
    // R2 pending lead: walk ticks, reading status each cycle
    for (int k = 0; k < 2 * P; k++) begin
      step(1, 0, 1, 0, 4'hD);
    end
    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      logic t, m, e, w;
      logic [3:0] a;
      t = ($urandom_range(2) == 0);
      m = ($urandom_range(15) == 0);
      e = ($urandom_range(2) == 0);
      w = $urandom_range(1);
      a = ($urandom_range(1) == 0) ? 4'hD : 4'($urandom_range(15));
      if ($urandom_range(31) == 0) ie = ~ie;
      if ($urandom_range(63) == 0) lowbat = ~lowbat;
      step(t, m, e, w, a);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule